// File: doc/BRIEF.md
# Row-Column Decoded Register RAM

A small synchronous-write, strobe-read memory of 16 words of 8 bits each. The words are held in a 4×4 grid of registers. The address is split into two fields. Each field goes to its own small decoder, which drives one-hot select lines. A word register is enabled only where its row line and its column line cross.

The write data bus reaches every word. Only the enabled word captures it, on a rising clock edge while the write strobe is high. Every word drives a shared output bus through a gate that opens only for the enabled word while the read strobe is high. When no read is active, the output bus is all zeros. A synchronous reset clears the whole grid.

Top module: `rcram_top`

## Requirements
- R1: There are 16 words of 8 bits. The 4-bit address `addr` selects a word: bits [3:2] give the row, bits [1:0] give the column, and the word index is row×4 + column. Address 0 is the cell at row 0, column 0.
- R2: The row decoder and the column decoder each drive exactly one active line. Exactly one word is enabled for any address, so the 16 addresses reach 16 distinct words.
- R3: When `wr_en` is 1 at a rising edge and `rst` is 0, the addressed word takes the value of `wr_data`. Every other word keeps its value, even though `wr_data` reaches all of them.
- R4: While `rd_en` is 1, `rd_data` equals the contents of the addressed word in the same cycle, with no clock edge in between.
- R5: While `rd_en` is 0, `rd_data` is 8'h00.
- R6: With both `wr_en` and `rd_en` at 0, no word changes, whatever `addr` and `wr_data` carry.
- R7: When `rd_en` and `wr_en` are both 1 in one cycle, `rd_data` shows the value the word held before the write. The new value appears from the next cycle.
- R8: When `rst` is 1 at a rising edge, all 16 words become 8'h00, and any write in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; words update on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all words |
| addr | input | 4 | Word address: row in [3:2], column in [1:0] |
| wr_data | input | 8 | Write data, broadcast to every word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Addressed word while reading, zero otherwise |

## Verification
The assertions run on every cycle and check four things:
- exactly one word is enabled;
- `rd_data` equals the enabled word while reading, and is zero while not reading;
- the enabled word holds the written data one edge after a write;
- a word that is not written is stable, and reset leaves every word at zero.

Some behaviours can only be shown by the bench's scenarios, which run against a behavioural model of the 16 words:
- that the address split really gives 16 distinct words, by writing unique values everywhere and reading them all back;
- that a read during a write returns the old value;
- that reset drops a write issued in the same cycle;
- that broadcast data with no strobe leaves the contents intact.

// File: rtl/rcram_pkg.sv
`timescale 1ns/1ps
package rcram_pkg;
  localparam int unsigned DEF_ROW_BITS = 2;
  localparam int unsigned DEF_COL_BITS = 2;
  localparam int unsigned DEF_DATA_W   = 8;
endpackage

// File: rtl/rcram_decoder.sv
`timescale 1ns/1ps
module rcram_decoder #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] lines
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/rcram_cell.sv
`timescale 1ns/1ps
module rcram_cell #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_line,
  input  logic              col_line,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] word_q;
  logic              cell_wr;

  assign hit     = row_line & col_line;
  assign cell_wr = hit & wr_en;
  assign held    = word_q;
  assign rd_q    = (hit & rd_en) ? word_q : '0;

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (cell_wr) word_q <= wr_data;
  end

  // R3 / R6: a word that is not written keeps its value
  a_r3_unwritten_stable: assert property (@(posedge clk) disable iff (rst)
    !(row_line && col_line && wr_en) |=> $stable(word_q));

  // R8: reset clears the word
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (word_q == '0));
endmodule

// File: rtl/rcram_top.sv
`timescale 1ns/1ps
module rcram_top
  import rcram_pkg::*;
#(
  parameter int unsigned ROW_BITS = DEF_ROW_BITS,
  parameter int unsigned COL_BITS = DEF_COL_BITS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  localparam int unsigned ADDR_W  = ROW_BITS + COL_BITS,
  localparam int unsigned ROWS    = 1 << ROW_BITS,
  localparam int unsigned COLS    = 1 << COL_BITS,
  localparam int unsigned WORDS   = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  logic [ROWS-1:0]   row_lines;
  logic [COLS-1:0]   col_lines;
  logic [WORDS-1:0]  cell_hit;
  logic [DATA_W-1:0] cell_held [WORDS];
  logic [DATA_W-1:0] cell_rd   [WORDS];

  rcram_decoder #(.SEL_W(ROW_BITS)) u_row_dec (
    .sel   (addr[ADDR_W-1:COL_BITS]),
    .lines (row_lines)
  );

  rcram_decoder #(.SEL_W(COL_BITS)) u_col_dec (
    .sel   (addr[COL_BITS-1:0]),
    .lines (col_lines)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      rcram_cell #(.DATA_W(DATA_W)) u_cell (
        .clk      (clk),
        .rst      (rst),
        .row_line (row_lines[r]),
        .col_line (col_lines[c]),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .hit      (cell_hit[r*COLS+c]),
        .held     (cell_held[r*COLS+c]),
        .rd_q     (cell_rd[r*COLS+c])
      );
    end
  end

  // shared output bus: wired-OR of the gated cell outputs
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < WORDS; i++) rd_data = rd_data | cell_rd[i];
  end

  // R2: the two decoders together enable exactly one word
  a_r2_one_cell: assert property (@(posedge clk) disable iff (rst)
    $countones(cell_hit) == 1);

  // R1 / R4 / R7: a read shows the addressed word as it currently stands
  a_r4_read_word: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_data == cell_held[addr]));

  // R5: the bus is quiet when no read is active
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rd_data == '0));

  // R3: a write lands in the addressed word
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cell_held[$past(addr)] == $past(wr_data)));
endmodule

// File: tb/rcram_top_tb.sv
`timescale 1ns/1ps
module rcram_top_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] addr;
  logic [7:0] wr_data;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] rd_data;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  logic [7:0] model [16];

  always #5 clk = ~clk;

  rcram_top u_dut (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, addr, act, exp);
    end
  endtask

  // Drive one cycle, check the combinational output, then advance the model.
  task automatic step(input string req, input logic r, input logic w, input logic rd,
                      input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    rst = r; wr_en = w; rd_en = rd; addr = a; wr_data = d;
    #1;
    check(req, rd_data, rd ? model[a] : 8'h00);
    @(posedge clk);
    if (r) for (int i = 0; i < 16; i++) model[i] = 8'h00;
    else if (w) model[a] = d;
  endtask

  initial begin
    logic [7:0] lfsr;
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0;
    for (int i = 0; i < 16; i++) model[i] = 8'hxx;
    step("R8", 1, 0, 0, 4'd0, 8'h00);
    step("R8", 1, 1, 0, 4'd3, 8'hAA);          // R8: write during reset is dropped
    // reset state: all words zero
    for (int i = 0; i < 16; i++) step("R8", 0, 0, 1, 4'(i), 8'hFF);
    // R1/R2: unique value in each of the 16 words, read-only strobe off -> R5
    for (int i = 0; i < 16; i++) step("R5", 0, 1, 0, 4'(i), 8'(8'h30 + i * 7));
    for (int i = 0; i < 16; i++) step("R1", 0, 0, 1, 4'(i), 8'h00);
    // R6: broadcast data with no strobe changes nothing
    for (int i = 0; i < 16; i++) step("R6", 0, 0, 0, 4'(i), 8'hC3);
    for (int i = 0; i < 16; i++) step("R6", 0, 0, 1, 4'(15 - i), 8'h5A);
    // R7: read during write returns old value, new value next cycle
    step("R7", 0, 1, 1, 4'd9, 8'hE1);
    step("R7", 0, 0, 1, 4'd9, 8'h00);
    step("R7", 0, 1, 1, 4'd0, 8'h1E);
    step("R7", 0, 1, 1, 4'd0, 8'h2F);
    step("R7", 0, 0, 1, 4'd0, 8'h00);
    // R3: single write, neighbours untouched
    step("R3", 0, 1, 0, 4'd5, 8'h77);
    for (int i = 0; i < 16; i++) step("R3", 0, 0, 1, 4'(i), 8'h00);
    // R4: mixed pattern
    lfsr = 8'hB5;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step("R4", 0, lfsr[0], lfsr[1], lfsr[7:4], lfsr ^ 8'(k));
    end
    // R8: reset mid-run clears everything
    step("R8", 1, 0, 1, 4'd2, 8'h00);
    for (int i = 0; i < 16; i++) step("R8", 0, 0, 1, 4'(i), 8'h00);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule